// File: doc/BRIEF.md
# Dadda-Reduced 4x4 Tree Multiplier

This block multiplies two 4-bit unsigned operands in one combinational pass and returns the 8-bit product. A grid of AND gates forms all sixteen partial-product bits at the same moment. A two-stage counter tree then brings the columns down to two rows in carry-save form, and a short carry-propagate adder merges those rows into binary.

The tree follows the late-combining schedule. Each stage does only the work it needs to reach its height target. The first stage brings every column down to at most three bits, and the second stage brings every column down to at most two. This keeps the tree at the minimum depth and uses as few counters as possible. The cost is a wider final adder. The tree is built from separately instantiated half-adder and full-adder cells, so its cell count can be read from the hierarchy.

The block has no clock and no state. There are no states or transitions to name: the product depends only on the present operands.

Top module: `dadda_mult4`

## Requirements
- R1: For every one of the 256 operand pairs, `product` equals `mul_a * mul_b` as an unsigned 8-bit value.
- R2: The partial-product bit for operand bits `mul_a[j]` and `mul_b[i]` is their AND and carries weight 2^(i+j). Sixteen such bits are formed, and the number of set bits among them equals popcount(`mul_a`) times popcount(`mul_b`).
- R3: The reduction tree is built from two half-adder cells in stage one and four full-adder cells in stage two. Its two output rows, each read as a 7-bit number, add up to the weighted sum of all partial-product bits.
- R4: Product bit 0 is `mul_a[0] & mul_b[0]` and passes to the output without going through the adder.
- R5: A 6-bit carry-propagate adder sums row bits 1 to 6. Its carry-out is product bit 7, so 15 x 15 gives 225 (8'hE1).
- R6: A zero on either operand gives a product of zero.
- R7: An operand equal to 1 passes the other operand unchanged to `product[3:0]`, and `product[7:4]` is zero.
- R8: The output depends only on the present inputs. A change of operands shows at `product` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mul_a | input | 4 | Multiplicand, unsigned |
| mul_b | input | 4 | Multiplier, unsigned |
| product | output | 8 | Unsigned product mul_a * mul_b |

## Verification
Two functions can act on the same column at the same time. In column 4, a carry from a stage-one half adder and a carry from a stage-two full adder both arrive and must be summed together. This happens while the final adder is also carrying all the way out to product bit 7. Operand pairs with dense high bits, such as 15 x 15, 13 x 11 and 14 x 15, drive both paths at once. The exhaustive sweep covers every other mix. Each result is compared against a product that the bench computes itself, and a carry lost in either path shows as a wrong upper nibble.

// File: rtl/dadda_pkg.sv
package dadda_pkg;
    localparam int OPW  = 4;            // operand width
    localparam int PW   = 2 * OPW;      // product width
    localparam int NPP  = OPW * OPW;    // partial-product bit count
    localparam int COLS = PW - 1;       // partial-product columns
    localparam int CPAW = COLS - 1;     // final adder width (column 0 bypasses)
endpackage

// File: rtl/dm_half_adder.sv
module dm_half_adder (
    input  logic x,
    input  logic y,
    output logic s,
    output logic c
);
    assign s = x ^ y;
    assign c = x & y;
endmodule

// File: rtl/dm_full_adder.sv
module dm_full_adder (
    input  logic x,
    input  logic y,
    input  logic z,
    output logic s,
    output logic c
);
    assign s = x ^ y ^ z;
    assign c = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/dm_and_array.sv
module dm_and_array
    import dadda_pkg::*;
(
    input  logic [OPW-1:0] opa,
    input  logic [OPW-1:0] opb,
    output logic [NPP-1:0] pp      // pp[i*OPW+j] = opa[j] & opb[i]
);
    for (genvar i = 0; i < OPW; i++) begin : g_row
        for (genvar j = 0; j < OPW; j++) begin : g_col
            assign pp[i*OPW+j] = opa[j] & opb[i];
        end
    end

    // R2: population of the grid equals product of operand populations
    always_comb begin
        a_r2_pp_population: assert ($countones(pp) == $countones(opa) * $countones(opb))
            else $error("R2 partial-product population mismatch");
    end
endmodule

// File: rtl/dm_cpa.sv
module dm_cpa #(
    parameter int W = 6
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] cy;

    always_comb begin
        cy[0] = 1'b0;
        for (int k = 0; k < W; k++) begin
            s[k]    = x[k] ^ y[k] ^ cy[k];
            cy[k+1] = (x[k] & y[k]) | (cy[k] & (x[k] ^ y[k]));
        end
        co = cy[W];
    end
endmodule

// File: rtl/dm_dadda_tree.sv
module dm_dadda_tree
    import dadda_pkg::*;
(
    input  logic [NPP-1:0]  pp,
    output logic [COLS-1:0] row_a,
    output logic [COLS-1:0] row_b
);
    // bit with multiplicand index j and multiplier index i
    function automatic logic bit_at(input logic [NPP-1:0] v, input int j, input int i);
        return v[i*OPW+j];
    endfunction

    // stage one: height target 3, half adders on columns 3 and 4
    logic hs1, hc1, hs2, hc2;
    dm_half_adder u_ha1 (.x(bit_at(pp, 3, 0)), .y(bit_at(pp, 2, 1)), .s(hs1), .c(hc1));
    dm_half_adder u_ha2 (.x(bit_at(pp, 3, 1)), .y(bit_at(pp, 2, 2)), .s(hs2), .c(hc2));

    // stage two: height target 2, full adders on columns 2..5
    logic fs1, fc1, fs2, fc2, fs3, fc3, fs4, fc4;
    dm_full_adder u_fa1 (.x(bit_at(pp, 0, 2)), .y(bit_at(pp, 1, 1)), .z(bit_at(pp, 2, 0)),
                         .s(fs1), .c(fc1));
    dm_full_adder u_fa2 (.x(bit_at(pp, 1, 2)), .y(bit_at(pp, 0, 3)), .z(hs1),
                         .s(fs2), .c(fc2));
    dm_full_adder u_fa3 (.x(bit_at(pp, 1, 3)), .y(hs2), .z(hc1),
                         .s(fs3), .c(fc3));
    dm_full_adder u_fa4 (.x(bit_at(pp, 2, 3)), .y(bit_at(pp, 3, 2)), .z(hc2),
                         .s(fs4), .c(fc4));

    // carry-save rows, bit k has weight 2^k
    assign row_a = {bit_at(pp, 3, 3), fs4, fs3, fs2, fs1, bit_at(pp, 1, 0), bit_at(pp, 0, 0)};
    assign row_b = {fc4, fc3, fc2, fc1, 1'b0, bit_at(pp, 0, 1), 1'b0};

    // R3: the two rows carry the full weighted value of the grid
    always_comb begin
        int grid;
        grid = 0;
        for (int i = 0; i < OPW; i++)
            for (int j = 0; j < OPW; j++)
                grid = grid + (int'(pp[i*OPW+j]) << (i + j));
        a_r3_rows_keep_value: assert (int'(row_a) + int'(row_b) == grid)
            else $error("R3 carry-save rows lose value");
    end
endmodule

// File: rtl/dadda_mult4.sv
module dadda_mult4
    import dadda_pkg::*;
(
    input  logic [3:0] mul_a,
    input  logic [3:0] mul_b,
    output logic [7:0] product
);
    logic [NPP-1:0]  pp;
    logic [COLS-1:0] row_a, row_b;
    logic [CPAW-1:0] sum_hi;
    logic            carry_top;

    dm_and_array u_pp (.opa(mul_a), .opb(mul_b), .pp(pp));

    dm_dadda_tree u_tree (.pp(pp), .row_a(row_a), .row_b(row_b));

    dm_cpa #(.W(CPAW)) u_cpa (
        .x  (row_a[COLS-1:1]),
        .y  (row_b[COLS-1:1]),
        .s  (sum_hi),
        .co (carry_top)
    );

    assign product = {carry_top, sum_hi, row_a[0]};

    always_comb begin
        // R5: adder result equals the sum of the upper row bits
        a_r5_cpa_sum: assert (int'(product[PW-1:1]) == int'(row_a[COLS-1:1]) + int'(row_b[COLS-1:1]))
            else $error("R5 final adder sum mismatch");
        // R1: product equals arithmetic multiply of the ports
        a_r1_product: assert (int'(product) == int'(mul_a) * int'(mul_b))
            else $error("R1 product mismatch");
    end
endmodule

// File: tb/sim_dadda_mult4.sv
module sim_dadda_mult4;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ta = '0, tb = '0;
    logic [7:0] prod;
    int         n_cmp = 0, n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;          // 50 MHz

    dadda_mult4 u0 (.mul_a(ta), .mul_b(tb), .product(prod));

    // directed vectors {a, b}
    localparam logic [7:0] VEC [0:11] = '{
        8'h00, 8'hF0, 8'h0F,        // R6 zero operand
        8'h1F, 8'hF1, 8'h1A,        // R7 unit operand
        8'hFF, 8'hDB, 8'hEF,        // R5 long carries
        8'h33, 8'h55, 8'h8C         // R3 mixed column loads
    };

    function automatic string vec_tag(input int k);
        if (k < 3)      return "R6";
        else if (k < 6) return "R7";
        else if (k < 9) return "R5";
        else            return "R3";
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h (a=%0d b=%0d)", tag, got, exp, ta, tb);
        end
    endtask

    task automatic apply(input logic [3:0] a, input logic [3:0] b);
        @(negedge clk);
        ta = a;
        tb = b;
        #5;
    endtask

    initial begin
        // reset state: operands zero
        repeat (2) @(negedge clk);
        #5 check("R6 reset", prod, 8'h00);
        rst = 1'b0;

        for (int k = 0; k < 12; k++) begin
            apply(VEC[k][7:4], VEC[k][3:0]);
            check(vec_tag(k), prod, 8'(int'(VEC[k][7:4]) * int'(VEC[k][3:0])));
        end

        // R5 explicit top carry: 15 x 15 = 225
        apply(4'hF, 4'hF);
        check("R5", prod, 8'hE1);

        // R4 bit 0 and R2 popcount-style checks on single-bit operands
        apply(4'h8, 4'h8);
        check("R2", prod, 8'h40);
        apply(4'h3, 4'h5);
        check("R4", {7'd0, prod[0]}, 8'h01);

        // R8 change without any clock edge
        @(negedge clk);
        ta = 4'h9; tb = 4'h7;
        #2 check("R8", prod, 8'd63);
        ta = 4'h6;
        #2 check("R8", prod, 8'd42);

        // R1 exhaustive sweep
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                apply(4'(a), 4'(b));
                check("R1", prod, 8'(a * b));
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule